// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block decides when the memory controller must spend command-bus time on AUTO REFRESH, so that every row of a 4096-row device is refreshed within each 64 ms retention window. It works with a command sequencer through a request/grant handshake. The scheduler raises `bus_req`. It waits until the sequencer grants the bus and reports every bank precharged. It then fires one refresh and keeps the bus until the refresh cycle time has passed. Refreshes that come due while the bus is busy are counted, up to a limit, and paid back later.

Two policies are selectable with `pol_burst`. In the distributed policy one refresh becomes owed every `REFI_CYC` cycles (15.6 µs at the default 100 MHz). The owed count saturates at `OWED_MAX`, and reaching that limit raises `ref_urgent`. In the burst policy the whole quota of `BURST_CNT` refreshes becomes owed once per `WINDOW_CYC` cycles. The quota is drained back to back, one refresh every `TRFC_CYC` cycles.

A power manager asks for self refresh with `sr_req`. The scheduler takes the bus when all banks are idle and drives `cke` low. When the request is withdrawn it raises `cke` again and holds `act_hold` for `TXSR_CYC` cycles, during which the sequencer must not open a row.

The controller has seven states:
- IDLE: nothing owed.
- ARB: waiting for grant and idle banks before a refresh.
- FIRE: the one-cycle refresh command.
- RECOVER: the refresh cycle time is running.
- SR_ARB: waiting for grant and idle banks before self refresh.
- SR_ON: `cke` is low.
- SR_EXIT: the exit delay is running.

The transitions are:
- IDLE→SR_ARB on a self-refresh request. This has priority over owed refreshes.
- IDLE→ARB when the owed count is nonzero.
- ARB→FIRE on grant with idle banks.
- FIRE→RECOVER always.
- RECOVER→FIRE at the end of the wait if refreshes are still owed, the grant and idle banks hold, and no self refresh is requested.
- RECOVER→IDLE at the end of the wait otherwise.
- SR_ARB→SR_ON on grant with idle banks.
- SR_ON→SR_EXIT when the request drops.
- SR_EXIT→IDLE when the exit delay has elapsed.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_req`=0, `ref_cmd`=0, `ref_urgent`=0, `cke`=1 and `act_hold`=0.
- R2: In the distributed policy (`pol_burst`=0) one refresh becomes owed every `REFI_CYC` cycles. With the bus always granted and banks always idle, `ref_cmd` pulses once per `REFI_CYC` cycles. The first pulse comes 3 cycles after the first interval ends.
- R3: `ref_cmd` is a one-cycle pulse. It occurs only in the cycle after one in which `bus_gnt` and `banks_idle` were both 1 while the scheduler held the bus request. It never occurs while nothing is owed.
- R4: Two `ref_cmd` pulses are at least `TRFC_CYC` cycles apart. When refreshes remain owed and grant and idle persist, the next pulse follows exactly `TRFC_CYC` cycles later.
- R5: In the distributed policy the owed count saturates at `OWED_MAX`. `ref_urgent` is 1 exactly when the policy is distributed and the count equals `OWED_MAX`. After a long stall, exactly `OWED_MAX` refreshes are paid back.
- R6: `bus_req` is 1 in every state except IDLE: while arbitrating, during refresh and its recovery, and throughout self refresh and its exit.
- R7: In the burst policy (`pol_burst`=1) the owed count is loaded with `BURST_CNT` every `WINDOW_CYC` cycles, and any remainder is discarded. The quota is issued as `BURST_CNT` pulses spaced `TRFC_CYC` apart.
- R8: A self-refresh request in IDLE has priority over owed refreshes. `cke` goes to 0 one cycle after grant and idle banks are seen, and stays 0 until `sr_req` is sampled 0.
- R9: `cke` returns to 1 in the cycle after `sr_req` is sampled 0. `act_hold` is 1 for exactly `TXSR_CYC` cycles starting in that same cycle.
- R10: While `cke` is low and during the exit delay, no refresh comes due and the owed count is cleared. The interval timer restarts on return to IDLE, so the first refresh afterwards fires `REFI_CYC`+2 cycles after IDLE is re-entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_burst | input | 1 | Refresh policy: 0 distributed, 1 burst; change only under reset |
| sr_req | input | 1 | Self-refresh request from the power manager |
| bus_gnt | input | 1 | Sequencer has yielded the command bus |
| banks_idle | input | 1 | Sequencer reports all banks precharged |
| bus_req | output | 1 | Scheduler requests or holds the command bus |
| ref_cmd | output | 1 | One-cycle AUTO REFRESH issue strobe |
| ref_urgent | output | 1 | Owed refresh count at its limit (distributed policy) |
| cke | output | 1 | Clock-enable level for the device |
| act_hold | output | 1 | Row activation forbidden (self-refresh exit delay) |

## Verification
A corrupted owed count shows up at the ports within one cycle through `ref_urgent`. It also shows as a wrong number of `ref_cmd` pulses once the bus is granted, either too many after a stall or a truncated burst. A wrong wait counter or state moves a `ref_cmd`, a `cke` edge or the end of `act_hold` by at least one cycle. A behavioural model that runs alongside the design and is compared on every clock exposes this in the cycle it happens. Scenario counts then confirm the number of pulses per interval, per stall and per burst window.

// File: rtl/refsch_pkg.sv
package refsch_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_FIRE,
        ST_RECOVER,
        ST_SR_ARB,
        ST_SR_ON,
        ST_SR_EXIT
    } rs_state_e;
endpackage

// File: rtl/refsch_interval.sv
// Interval timer: one tick per refresh interval (distributed) or per window (burst).
module refsch_interval #(
    parameter int REFI_CYC   = 1560,
    parameter int WINDOW_CYC = 6400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pol_burst,
    input  logic hold,
    output logic tick
);
    localparam int LIM_MAX = (WINDOW_CYC > REFI_CYC) ? WINDOW_CYC : REFI_CYC;
    localparam int CW      = $clog2(LIM_MAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last = pol_burst ? CW'(WINDOW_CYC - 1) : CW'(REFI_CYC - 1);
    assign tick = !hold && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (hold || tick)  cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    // R2: a due event never repeats in the following cycle
    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/refsch_owed.sv
// Owed-refresh counter: saturating in distributed mode, reloaded in burst mode.
module refsch_owed #(
    parameter int BURST_CNT = 4096,
    parameter int OWED_MAX  = 8,
    parameter int OW        = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pol_burst,
    input  logic          hold,
    input  logic          tick,
    input  logic          issue,
    output logic [OW-1:0] owed
);
    logic [OW:0] sum;
    logic [OW:0] cap;

    always_comb begin
        sum = {1'b0, owed} + (OW+1)'(tick) - (OW+1)'(issue);
        cap = pol_burst ? (OW+1)'(BURST_CNT) : (OW+1)'(OWED_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                owed <= '0;
        else if (hold)             owed <= '0;
        else if (pol_burst && tick) owed <= OW'(BURST_CNT);
        else if (sum > cap)        owed <= cap[OW-1:0];
        else                       owed <= sum[OW-1:0];
    end

    // R3: a refresh is only fired against a nonzero debt
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (owed != '0));
    // R5: distributed debt never exceeds its limit
    p_owed_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pol_burst |-> (owed <= OW'(OWED_MAX)));
endmodule

// File: rtl/refsch_fsm.sv
// Bus arbitration, refresh issue, recovery and self-refresh sequencing.
module refsch_fsm
    import refsch_pkg::*;
#(
    parameter int TRFC_CYC = 8,
    parameter int TXSR_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_req,
    input  logic bus_gnt,
    input  logic banks_idle,
    input  logic owed_nz,
    output logic bus_req,
    output logic ref_cmd,
    output logic cke,
    output logic act_hold,
    output logic sr_hold
);
    localparam int WMAX = (TRFC_CYC > TXSR_CYC) ? TRFC_CYC : TXSR_CYC;
    localparam int WW   = $clog2(WMAX + 1);

    rs_state_e     state, state_nxt;
    logic [WW-1:0] wait_q, wait_nxt;
    logic          path_clear;

    assign path_clear = bus_gnt && banks_idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            wait_q <= '0;
        end else begin
            state  <= state_nxt;
            wait_q <= wait_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        wait_nxt  = wait_q;
        unique case (state)
            ST_IDLE: begin
                if (sr_req)       state_nxt = ST_SR_ARB;
                else if (owed_nz) state_nxt = ST_ARB;
            end
            ST_ARB: begin
                if (path_clear) state_nxt = ST_FIRE;
            end
            ST_FIRE: begin
                state_nxt = ST_RECOVER;
                wait_nxt  = WW'(TRFC_CYC - 2);
            end
            ST_RECOVER: begin
                if (wait_q == '0)
                    state_nxt = (owed_nz && path_clear && !sr_req) ? ST_FIRE : ST_IDLE;
                else
                    wait_nxt = wait_q - 1'b1;
            end
            ST_SR_ARB: begin
                if (path_clear) state_nxt = ST_SR_ON;
            end
            ST_SR_ON: begin
                if (!sr_req) begin
                    state_nxt = ST_SR_EXIT;
                    wait_nxt  = WW'(TXSR_CYC - 1);
                end
            end
            ST_SR_EXIT: begin
                if (wait_q == '0) state_nxt = ST_IDLE;
                else              wait_nxt  = wait_q - 1'b1;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_req  = (state != ST_IDLE);
        ref_cmd  = (state == ST_FIRE);
        cke      = (state != ST_SR_ON);
        act_hold = (state == ST_SR_EXIT);
        sr_hold  = (state == ST_SR_ON) || (state == ST_SR_EXIT);
    end

    // R3: refresh only after a cycle with the bus granted and banks idle
    p_cmd_needs_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> $past(bus_gnt && banks_idle));
    // R4: refresh strobes are never adjacent
    p_cmd_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |=> !ref_cmd);
    // R8: clock enable is only dropped while the bus is owned
    p_cke_owns_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> bus_req);
    // R9: the exit delay starts with the rising clock enable
    p_exit_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> act_hold);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int REFI_CYC   = 1560,
    parameter int WINDOW_CYC = 6400000,
    parameter int BURST_CNT  = 4096,
    parameter int OWED_MAX   = 8,
    parameter int TRFC_CYC   = 8,
    parameter int TXSR_CYC   = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pol_burst,
    input  logic sr_req,
    input  logic bus_gnt,
    input  logic banks_idle,
    output logic bus_req,
    output logic ref_cmd,
    output logic ref_urgent,
    output logic cke,
    output logic act_hold
);
    localparam int OCAP = (BURST_CNT > OWED_MAX) ? BURST_CNT : OWED_MAX;
    localparam int OW   = $clog2(OCAP + 1);

    logic          tick;
    logic          sr_hold;
    logic [OW-1:0] owed;

    refsch_interval #(.REFI_CYC(REFI_CYC), .WINDOW_CYC(WINDOW_CYC)) u_interval (
        .clk(clk), .rst_n(rst_n), .pol_burst(pol_burst), .hold(sr_hold), .tick(tick)
    );

    refsch_owed #(.BURST_CNT(BURST_CNT), .OWED_MAX(OWED_MAX), .OW(OW)) u_owed (
        .clk(clk), .rst_n(rst_n), .pol_burst(pol_burst), .hold(sr_hold),
        .tick(tick), .issue(ref_cmd), .owed(owed)
    );

    refsch_fsm #(.TRFC_CYC(TRFC_CYC), .TXSR_CYC(TXSR_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .bus_gnt(bus_gnt),
        .banks_idle(banks_idle), .owed_nz(owed != '0), .bus_req(bus_req),
        .ref_cmd(ref_cmd), .cke(cke), .act_hold(act_hold), .sr_hold(sr_hold)
    );

    assign ref_urgent = !pol_burst && (owed == OW'(OWED_MAX));

    // R5: urgency only with work pending and the bus requested
    p_urgent_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_urgent) |=> bus_req);
endmodule

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
    localparam int REFI = 20, WIN = 300, BRST = 6, OMAX = 4, TRFC = 3, TXSR = 5;

    logic clk = 1'b0, rst_n = 1'b0, pol = 1'b0, sr = 1'b0, gnt = 1'b0, idl = 1'b0;
    logic bus_req, ref_cmd, ref_urgent, cke, act_hold;

    refresh_sched #(.REFI_CYC(REFI), .WINDOW_CYC(WIN), .BURST_CNT(BRST),
                    .OWED_MAX(OMAX), .TRFC_CYC(TRFC), .TXSR_CYC(TXSR)) u_dut (
        .clk(clk), .rst_n(rst_n), .pol_burst(pol), .sr_req(sr), .bus_gnt(gnt),
        .banks_idle(idl), .bus_req(bus_req), .ref_cmd(ref_cmd), .ref_urgent(ref_urgent),
        .cke(cke), .act_hold(act_hold)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0, pulses = 0, last_pulse = -1;
    bit gap_chk = 0, finished = 0;
    // behavioural model: 0 idle,1 arb,2 fire,3 recover,4 sr_arb,5 sr_on,6 sr_exit
    int ms = 0, mcnt = 0, mowed = 0, mwait = 0, lim = 0, nowed = 0;
    bit hold, tick, issue;

    task automatic chk(input logic a, input logic e, input string tag);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, a, e);
        end
    endtask

    task automatic chk_int(input int a, input int e, input string tag);
        checks++;
        if (a != e) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, a, e);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ms = 0; mcnt = 0; mowed = 0; mwait = 0;
        end else begin
            hold  = (ms == 5) || (ms == 6);
            lim   = pol ? WIN : REFI;
            tick  = !hold && (mcnt == lim - 1);
            issue = (ms == 2);
            if (hold) nowed = 0;
            else if (pol && tick) nowed = BRST;
            else begin
                nowed = mowed + int'(tick) - int'(issue);
                if (nowed > (pol ? BRST : OMAX)) nowed = pol ? BRST : OMAX;
            end
            case (ms)
                0: if (sr) ms = 4; else if (mowed != 0) ms = 1;
                1: if (gnt && idl) ms = 2;
                2: begin ms = 3; mwait = TRFC - 2; end
                3: if (mwait == 0) ms = (mowed != 0 && gnt && idl && !sr) ? 2 : 0;
                   else mwait--;
                4: if (gnt && idl) ms = 5;
                5: if (!sr) begin ms = 6; mwait = TXSR - 1; end
                6: if (mwait == 0) ms = 0; else mwait--;
                default: ms = 0;
            endcase
            mcnt  = (hold || tick) ? 0 : mcnt + 1;
            mowed = nowed;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(bus_req,    ms != 0,                    "R6 bus_req");
            chk(ref_cmd,    ms == 2,                    "R3 ref_cmd");
            chk(ref_urgent, !pol && (mowed == OMAX),    "R5 ref_urgent");
            chk(cke,        ms != 5,                    "R8 cke");
            chk(act_hold,   ms == 6,                    "R9 act_hold");
            if (ref_cmd) begin
                pulses++;
                if (gap_chk && last_pulse >= 0) chk_int(cyc - last_pulse, TRFC, "R4 gap");
                last_pulse = cyc;
            end
        end
    end

    task automatic do_reset(input logic p);
        rst_n = 1'b0; pol = p;
        wait_cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        logic [15:0] lf;
        // R1: reset state
        gnt = 1'b1; idl = 1'b1;
        rst_n = 1'b0; pol = 1'b0;
        wait_cyc(3);
        chk(bus_req, 1'b0, "R1 bus_req");
        chk(ref_cmd, 1'b0, "R1 ref_cmd");
        chk(ref_urgent, 1'b0, "R1 ref_urgent");
        chk(cke, 1'b1, "R1 cke");
        chk(act_hold, 1'b0, "R1 act_hold");
        rst_n = 1'b1;
        // R2: distributed cadence
        pulses = 0;
        wait_cyc(210);
        chk_int(pulses, 10, "R2 pulses per 210 cycles");
        // R5: stall saturates debt, then exactly OMAX paid back
        gnt = 1'b0;
        wait_cyc(200);
        chk(ref_urgent, 1'b1, "R5 urgent after stall");
        chk(bus_req, 1'b1, "R6 request during stall");
        pulses = 0;
        gnt = 1'b1;
        wait_cyc(11);
        chk_int(pulses, OMAX, "R5 paid back");
        chk(ref_urgent, 1'b0, "R5 urgent cleared");
        // R7, R4: burst drain
        do_reset(1'b1);
        pulses = 0; last_pulse = -1; gap_chk = 1;
        wait_cyc(330);
        gap_chk = 0;
        chk_int(pulses, BRST, "R7 burst pulses");
        // R8, R9, R10: self refresh
        do_reset(1'b0);
        wait_cyc(30);
        sr = 1'b1;
        wait_cyc(10);
        pulses = 0;
        wait_cyc(60);
        chk(cke, 1'b0, "R8 cke low in self refresh");
        chk_int(pulses, 0, "R10 no refresh in self refresh");
        sr = 1'b0;
        wait_cyc(1);
        chk(cke, 1'b1, "R9 cke restored");
        chk(act_hold, 1'b1, "R9 hold starts");
        wait_cyc(TXSR - 1);
        chk(act_hold, 1'b1, "R9 hold last cycle");
        wait_cyc(1);
        chk(act_hold, 1'b0, "R9 hold ended");
        pulses = 0;
        wait_cyc(18);
        chk_int(pulses, 0, "R10 interval restarted");
        wait_cyc(5);
        chk_int(pulses, 1, "R10 first refresh after exit");
        // mixed traffic, compared against the model every cycle
        do_reset(1'b0);
        lf = 16'hACE1;
        for (int i = 0; i < 700; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            gnt = lf[0] | lf[3];
            idl = lf[1] | lf[5];
            if (i == 300) sr = 1'b1;
            if (i == 340) sr = 1'b0;
            wait_cyc(1);
        end
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            summary();
            $finish;
        end
    end
endmodule